// File: doc/BRIEF.md
# Dual-Port Same-Location Busy Arbiter

This block watches the two ports of a dual-port memory and decides what happens when both select the same location at once. It compares the two addresses and the two select lines every clock. When both ports are selected on one address, it raises a busy flag toward the port that got there later. It also gates that port's write strobe, so the array is never written from the side that lost.

The decision uses only the select and address of each port. A port counts as arriving in a cycle when it becomes selected, or when it is selected and its address differs from the previous cycle. If both ports arrive in the same cycle, a registered toggle picks the winner and then alternates. Once a collision has a winner, that winner is held for as long as both ports stay selected on a common address.

A mode input turns the block into a follower for width expansion. In that mode it does no arbitration and drives no busy flags. Instead, external busy inputs from a leading instance block writes on their own port. All outputs are registered, so each one reflects the inputs of the previous clock.

Top module: `dpa_busy_arb`

## Requirements
- R1: `l_busy_o`/`r_busy_o` (1 = busy) can be 1 only if, one clock earlier, both `l_sel` and `r_sel` were 1 with `l_addr == r_addr` and `follow` was 0. Otherwise both read 0.
- R2: The write request inputs `l_wr`/`r_wr` have no influence on which side is flagged busy.
- R3: In a collision where one port arrived in an earlier cycle than the other, the later port's busy output is 1 on the clock after the match and the earlier port's is 0.
- R4: `l_busy_o` and `r_busy_o` are never both 1.
- R5: A write grant (`l_wr_go`/`r_wr_go`) is 1 one clock after that port had select and write request at 1 while it was not the internally chosen busy side. A busy port's write is never granted.
- R6: With `follow` = 1, both busy outputs are 0 and a port's write grant is suppressed while its `l_busy_i`/`r_busy_i` input was 1 in the prior cycle.
- R7: Busy clears on the clock after the addresses stop matching or either select falls, and the held port's write is then granted.
- R8: When both ports arrive on the same address in the same cycle, the first such tie after reset goes to the left port (right busy) and later ties alternate.
- R9: During an ongoing collision the winner is held. If both addresses move together to a new common location, the same side stays busy.
- R10: Synchronous active-high `rst` drives all four outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| follow | input | 1 | 1 = follower mode (busy comes in from outside) |
| l_sel | input | 1 | Left port selected |
| l_wr | input | 1 | Left port write request |
| l_addr | input | AW | Left port address |
| l_busy_i | input | 1 | Left busy input, used in follower mode |
| r_sel | input | 1 | Right port selected |
| r_wr | input | 1 | Right port write request |
| r_addr | input | AW | Right port address |
| r_busy_i | input | 1 | Right busy input, used in follower mode |
| l_busy_o | output | 1 | Left port is held off |
| r_busy_o | output | 1 | Right port is held off |
| l_wr_go | output | 1 | Left write granted to the array |
| r_wr_go | output | 1 | Right write granted to the array |

## Verification
Arbitration and write gating act in the same clock: a port can request a write in the very cycle it loses a collision. The bench provokes this by having both ports write while arriving on one address, in staggered cycles, in tied cycles and with both moving together. In every such step, the write grant of the losing side must be 0 while the winner's grant is 1, and both busy flags must never be 1 together.

// File: rtl/dpa_pkg.sv
package dpa_pkg;
  typedef enum logic {
    SIDE_L = 1'b0,
    SIDE_R = 1'b1
  } side_e;

  function automatic side_e other_side(input side_e s);
    return (s == SIDE_L) ? SIDE_R : SIDE_L;
  endfunction
endpackage

// File: rtl/dpa_arrival.sv
module dpa_arrival #(
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sel,
  input  logic [AW-1:0] addr,
  output logic          fresh
);
  logic          sel_q;
  logic [AW-1:0] addr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q  <= 1'b0;
      addr_q <= '0;
    end else begin
      sel_q  <= sel;
      addr_q <= addr;
    end
  end

  // a port arrives when it becomes selected or moves while selected
  assign fresh = sel && (!sel_q || (addr != addr_q));
endmodule

// File: rtl/dpa_decide.sv
module dpa_decide
  import dpa_pkg::*;
#(
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          follow,
  input  logic          l_sel,
  input  logic          r_sel,
  input  logic [AW-1:0] l_addr,
  input  logic [AW-1:0] r_addr,
  input  logic          l_fresh,
  input  logic          r_fresh,
  output logic          l_busy_n,
  output logic          r_busy_n
);
  logic  match;
  logic  coll_q, coll_d;
  side_e win_q, win_d;
  side_e tie_q, tie_d;

  assign match = !follow && l_sel && r_sel && (l_addr == r_addr);

  always_comb begin
    coll_d = 1'b0;
    win_d  = win_q;
    tie_d  = tie_q;
    if (match) begin
      coll_d = 1'b1;
      if (!coll_q) begin
        if (l_fresh && !r_fresh) begin
          win_d = SIDE_R;
        end else if (r_fresh && !l_fresh) begin
          win_d = SIDE_L;
        end else begin
          win_d = tie_q;
          tie_d = other_side(tie_q);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      coll_q <= 1'b0;
      win_q  <= SIDE_L;
      tie_q  <= SIDE_L;
    end else begin
      coll_q <= coll_d;
      win_q  <= win_d;
      tie_q  <= tie_d;
    end
  end

  assign l_busy_n = match && (win_d == SIDE_R);
  assign r_busy_n = match && (win_d == SIDE_L);

  // R9
  held_winner_chk: assert property (@(posedge clk) disable iff (rst)
    (coll_q && $past(coll_q)) |-> $stable(win_q));
endmodule

// File: rtl/dpa_wgate.sv
module dpa_wgate (
  input  logic sel,
  input  logic wr,
  input  logic follow,
  input  logic busy_int,
  input  logic busy_ext,
  output logic go
);
  logic blocked;
  assign blocked = follow ? busy_ext : busy_int;
  assign go      = sel && wr && !blocked;
endmodule

// File: rtl/dpa_busy_arb.sv
module dpa_busy_arb #(
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          follow,
  input  logic          l_sel,
  input  logic          l_wr,
  input  logic [AW-1:0] l_addr,
  input  logic          l_busy_i,
  input  logic          r_sel,
  input  logic          r_wr,
  input  logic [AW-1:0] r_addr,
  input  logic          r_busy_i,
  output logic          l_busy_o,
  output logic          r_busy_o,
  output logic          l_wr_go,
  output logic          r_wr_go
);
  localparam int NPORT = 2;

  logic [NPORT-1:0]   sel_v, wr_v, fresh_v, bin_v, bint_v, go_v;
  logic [AW-1:0]      addr_v [NPORT];

  assign sel_v     = {r_sel, l_sel};
  assign wr_v      = {r_wr, l_wr};
  assign bin_v     = {r_busy_i, l_busy_i};
  assign addr_v[0] = l_addr;
  assign addr_v[1] = r_addr;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    dpa_arrival #(.AW(AW)) i_arr (
      .clk  (clk),
      .rst  (rst),
      .sel  (sel_v[p]),
      .addr (addr_v[p]),
      .fresh(fresh_v[p])
    );
    dpa_wgate i_gate (
      .sel     (sel_v[p]),
      .wr      (wr_v[p]),
      .follow  (follow),
      .busy_int(bint_v[p]),
      .busy_ext(bin_v[p]),
      .go      (go_v[p])
    );
  end

  dpa_decide #(.AW(AW)) i_dec (
    .clk     (clk),
    .rst     (rst),
    .follow  (follow),
    .l_sel   (l_sel),
    .r_sel   (r_sel),
    .l_addr  (l_addr),
    .r_addr  (r_addr),
    .l_fresh (fresh_v[0]),
    .r_fresh (fresh_v[1]),
    .l_busy_n(bint_v[0]),
    .r_busy_n(bint_v[1])
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      l_busy_o <= 1'b0;
      r_busy_o <= 1'b0;
      l_wr_go  <= 1'b0;
      r_wr_go  <= 1'b0;
    end else begin
      l_busy_o <= bint_v[0];
      r_busy_o <= bint_v[1];
      l_wr_go  <= go_v[0];
      r_wr_go  <= go_v[1];
    end
  end

  // R4
  busy_mutex_chk: assert property (@(posedge clk) disable iff (rst)
    !(l_busy_o && r_busy_o));

  // R1
  busy_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(l_busy_o) || $rose(r_busy_o) |->
      $past(!follow && l_sel && r_sel && (l_addr == r_addr)));

  // R5
  go_not_busy_chk: assert property (@(posedge clk) disable iff (rst)
    !(l_wr_go && l_busy_o) && !(r_wr_go && r_busy_o));

  // R6
  follow_block_chk: assert property (@(posedge clk) disable iff (rst)
    $past(follow && l_busy_i) |-> (!l_wr_go && !l_busy_o && !r_busy_o));
endmodule

// File: tb/test_dpa_busy_arb.sv
module test_dpa_busy_arb;
  localparam int AW = 11;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          follow = 1'b0;
  logic          l_sel = 1'b0, l_wr = 1'b0, l_busy_i = 1'b0;
  logic          r_sel = 1'b0, r_wr = 1'b0, r_busy_i = 1'b0;
  logic [AW-1:0] l_addr = '0, r_addr = '0;
  logic          l_busy_o, r_busy_o, l_wr_go, r_wr_go;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  bit done  = 1'b0;

  typedef struct {
    int       due;
    logic [3:0] exp;   // {l_busy, r_busy, l_go, r_go}
    string    tag;
  } item_t;
  item_t sb[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dpa_busy_arb #(.AW(AW)) i_dpa_busy_arb (
    .clk(clk), .rst(rst), .follow(follow),
    .l_sel(l_sel), .l_wr(l_wr), .l_addr(l_addr), .l_busy_i(l_busy_i),
    .r_sel(r_sel), .r_wr(r_wr), .r_addr(r_addr), .r_busy_i(r_busy_i),
    .l_busy_o(l_busy_o), .r_busy_o(r_busy_o),
    .l_wr_go(l_wr_go), .r_wr_go(r_wr_go)
  );

  // monitor: R4 every cycle, scoreboard pops when due
  always @(negedge clk) begin
    if (!rst) begin
      total = total + 1;
      if (l_busy_o && r_busy_o) begin
        bad = bad + 1;
        $display("FAIL R4 mutex: actual=11 expected not both");
      end
    end
    if (sb.size() > 0 && sb[0].due == cyc) begin
      item_t it;
      it = sb.pop_front();
      total = total + 1;
      if ({l_busy_o, r_busy_o, l_wr_go, r_wr_go} !== it.exp) begin
        bad = bad + 1;
        $display("FAIL %s: actual=%b expected=%b", it.tag,
                 {l_busy_o, r_busy_o, l_wr_go, r_wr_go}, it.exp);
      end
    end
  end

  task automatic drive(input logic ls, input logic lw, input int la,
                       input logic rs, input logic rw, input int ra,
                       input logic [3:0] exp, input string tag);
    @(negedge clk);
    l_sel = ls; l_wr = lw; l_addr = AW'(la);
    r_sel = rs; r_wr = rw; r_addr = AW'(ra);
    sb.push_back('{due: cyc + 1, exp: exp, tag: tag});
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10 reset state
    total = total + 1;
    if ({l_busy_o, r_busy_o, l_wr_go, r_wr_go} !== 4'b0000) begin
      bad = bad + 1;
      $display("FAIL R10: actual=%b expected=0000",
               {l_busy_o, r_busy_o, l_wr_go, r_wr_go});
    end
    rst = 1'b0;

    // R1/R5 left alone writes
    drive(1, 1, 5, 0, 0, 0, 4'b0010, "R1 lone left");
    // R3 right arrives later on 5, both write: right busy, left granted
    drive(1, 1, 5, 1, 1, 5, 4'b0110, "R3 late right");
    // R2 left now reads: right stays busy
    drive(1, 0, 5, 1, 1, 5, 4'b0100, "R2 read ignored");
    // R7 right moves away: released, write granted
    drive(1, 0, 5, 1, 1, 6, 4'b0001, "R7 addr release");
    // R3 left moves onto 6 later: left busy
    drive(1, 1, 6, 1, 1, 6, 4'b1001, "R3 late left");
    // R7 left deselects
    drive(0, 1, 6, 1, 1, 6, 4'b0001, "R7 deselect release");
    drive(0, 0, 0, 0, 0, 0, 4'b0000, "R1 idle");
    // R8 first tie: left wins
    drive(1, 1, 9, 1, 1, 9, 4'b0110, "R8 tie one");
    drive(0, 0, 0, 0, 0, 0, 4'b0000, "R1 idle");
    // R8 second tie: right wins
    drive(1, 1, 9, 1, 1, 9, 4'b1001, "R8 tie two");
    // R9 both move together: right still wins
    drive(1, 1, 12, 1, 1, 12, 4'b1001, "R9 held winner");
    // R1 different addresses
    drive(1, 1, 3, 1, 1, 4, 4'b0011, "R1 no match");
    // R1 same address, one deselected
    drive(1, 1, 4, 0, 1, 4, 4'b0010, "R1 one deselected");
    drive(0, 0, 0, 0, 0, 0, 4'b0000, "R1 idle");

    // R6 follower mode
    @(negedge clk);
    follow = 1'b1; l_busy_i = 1'b1; r_busy_i = 1'b0;
    drive(1, 1, 7, 1, 1, 7, 4'b0001, "R6 follow left blocked");
    @(negedge clk);
    l_busy_i = 1'b0; r_busy_i = 1'b1;
    sb.push_back('{due: cyc + 1, exp: 4'b0010, tag: "R6 follow right blocked"});
    @(negedge clk);
    l_busy_i = 1'b0; r_busy_i = 1'b0;
    sb.push_back('{due: cyc + 1, exp: 4'b0011, tag: "R6 follow both free"});
    repeat (4) @(negedge clk);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule